// File: doc/BRIEF.md
# BCD Digit Scanner with Strobe

This block sits behind the conversion sequencer of a dual-slope measurement front end. When the sequencer reports a finished conversion, the block captures the five BCD digits and the overrange flag. It then sends them out one digit at a time: five active-high, one-hot digit enables select a digit, and a 4-bit BCD bus carries that digit's value.

During the first scan after each new result, the block pulses an active-low strobe in the middle of every digit slot. External latches, a UART bridge or a processor can use these pulses to capture the reading. After that first scan the digits keep cycling for the display, but no more strobes are issued.

An overranged reading shows all-zero data. After its last strobe the display is blanked until the sequencer starts its next reference-integrate phase, so an overranged display blinks.

Top module: `bcd_scanner`

## Requirements
- R1: After reset, every digit enable is low, the BCD bus is 0 and the strobe is high. The block stays in this state, and ignores the reference-integrate start input, until the first result arrives.
- R2: Once a result is loaded, the digit enables scan one-hot in the order most significant digit first, least significant digit last, and this repeats without end. digitEn[4] is the most significant digit and digitEn[0] the least significant.
- R3: The most significant digit slot lasts 201 clocks. Each of the other four slots lasts 200 clocks. The first slot starts at the clock edge that samples the result-valid pulse.
- R4: The strobe is low only during the first half of a clock cycle. For the first slot it goes low at the clock edge 101 cycles after the edge that sampled the result. For every other slot it goes low 100 edges after that slot's enable rose.
- R5: Exactly five strobe pulses follow each result, one per slot of the first scan. Later scans issue no strobe.
- R6: The BCD bus carries the digit whose enable is high. resultDigits[19:16] holds the most significant digit and resultDigits[3:0] the least significant, each in 8-4-2-1 true-high form. The bus changes in the same cycle as the enables and is 0 when no enable is high.
- R7: For a result flagged as overrange, the BCD bus stays 0 in every cycle until the next result.
- R8: For an overrange result, all enables go low at the edge of the fifth strobe and stay low until a reference-integrate start pulse. The scan then resumes at the most significant digit with a 201-clock slot and no strobes.
- R9: A result arriving in the middle of a scan restarts the scan at the most significant digit, with new data and a fresh set of five strobes.
- R10: A reference-integrate start pulse has no effect while the display is not blanked.
- R11: If a result and a reference-integrate start pulse arrive in the same cycle, the result takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; scanning on the rising edge, strobe release on the falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| resultValid | input | 1 | One-cycle pulse: a new conversion result is present |
| resultDigits | input | 20 | Five BCD digits, most significant in the top nibble |
| resultOvr | input | 1 | The result presented with resultValid is overranged |
| refIntStart | input | 1 | One-cycle pulse at the start of a reference-integrate phase |
| digitEn | output | 5 | One-hot digit enables, bit 4 = most significant digit |
| bcdOut | output | 4 | BCD value of the enabled digit |
| strobeN | output | 1 | Active-low half-clock capture strobe |

## Verification
The state hardest to reach from the ports is the blanked display after an overranged result, together with its release. The display only blanks after the fifth strobe, about 900 cycles into a scan, and only a pulse that is otherwise ignored releases it. A result that collides with that release pulse is harder still. Directed runs therefore load overranged results, wait past the fifth strobe, hold the blank for a random time and then release it, once with a result in the same cycle. Random phases then scatter results, overrange flags and release pulses over scans that are in progress.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
  // Width of the digit selector carried from control to datapath (up to 16 digits).
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_BLANK = 2'd2
  } scanState_e;

  typedef struct packed {
    logic             loadResult;  // capture digits and overrange flag this edge
    logic             showDigit;   // a digit slot is being driven
    logic [SEL_W-1:0] digitSel;    // 0 = most significant digit
  } scanCtl_t;
endpackage

// File: rtl/bcd_scan_strobe.sv
module bcd_scan_strobe (
  input  logic clk,
  input  logic rstN,
  input  logic fire,
  output logic strobeN
);
  logic riseT;
  logic fallT;

  // Toggle on the rising edge, follow on the falling edge: the two differ only
  // during the first half of the cycle after a fire, and only one flop moves at a time.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     riseT <= 1'b0;
    else if (fire) riseT <= ~riseT;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallT <= 1'b0;
    else       fallT <= riseT;
  end

  assign strobeN = ~(riseT ^ fallT);

  // R4: the low phase has ended by every rising edge
  p_strobe_half_r4: assert property (@(posedge clk) disable iff (!rstN) strobeN)
    else $error("strobe still low at rising edge");
endmodule

// File: rtl/bcd_scan_ctrl.sv
module bcd_scan_ctrl
  import bcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS  = 5,
  parameter int LEAD_SLOT   = 201,
  parameter int SLOT        = 200,
  parameter int LEAD_STROBE = 101,
  parameter int STROBE_AT   = 100
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  resultValid,
  input  logic                  resultOvr,
  input  logic                  refIntStart,
  output scanCtl_t              ctl,
  output logic                  strobeFire,
  output logic [NUM_DIGITS-1:0] digitEn
);
  localparam int MAX_SLOT = (LEAD_SLOT > SLOT) ? LEAD_SLOT : SLOT;
  localparam int CNT_W    = $clog2(MAX_SLOT + 1);
  localparam int PEND_W   = $clog2(NUM_DIGITS + 1);
  localparam logic [CNT_W-1:0]  LEAD_LAST = CNT_W'(LEAD_SLOT - 1);
  localparam logic [CNT_W-1:0]  STD_LAST  = CNT_W'(SLOT - 1);
  localparam logic [CNT_W-1:0]  LEAD_FIRE = CNT_W'(LEAD_STROBE - 1);
  localparam logic [CNT_W-1:0]  STD_FIRE  = CNT_W'(STROBE_AT - 1);
  localparam logic [SEL_W-1:0]  LAST_SEL  = SEL_W'(NUM_DIGITS - 1);
  localparam logic [PEND_W-1:0] PEND_FULL = PEND_W'(NUM_DIGITS);

  scanState_e        stateQ;
  logic [SEL_W-1:0]  selQ;
  logic [CNT_W-1:0]  cntQ;
  logic [PEND_W-1:0] pendQ;
  logic              ovrQ;

  logic [CNT_W-1:0] slotLast;
  logic [CNT_W-1:0] fireAt;
  logic             fire;
  logic             lastFire;
  logic             slotEnd;

  always_comb begin
    slotLast = (selQ == '0) ? LEAD_LAST : STD_LAST;
    fireAt   = (selQ == '0) ? LEAD_FIRE : STD_FIRE;
    fire     = (stateQ == ST_SCAN) && !resultValid && (pendQ != '0) && (cntQ == fireAt);
    lastFire = fire && (pendQ == PEND_W'(1));
    slotEnd  = (cntQ == slotLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      selQ   <= '0;
      cntQ   <= '0;
      pendQ  <= '0;
      ovrQ   <= 1'b0;
    end else if (resultValid) begin
      stateQ <= ST_SCAN;
      selQ   <= '0;
      cntQ   <= '0;
      pendQ  <= PEND_FULL;
      ovrQ   <= resultOvr;
    end else begin
      unique case (stateQ)
        ST_SCAN: begin
          if (fire) pendQ <= pendQ - PEND_W'(1);
          if (lastFire && ovrQ) begin
            stateQ <= ST_BLANK;
            selQ   <= '0;
            cntQ   <= '0;
          end else if (slotEnd) begin
            cntQ <= '0;
            selQ <= (selQ == LAST_SEL) ? '0 : selQ + SEL_W'(1);
          end else begin
            cntQ <= cntQ + CNT_W'(1);
          end
        end
        ST_BLANK: begin
          if (refIntStart) begin
            stateQ <= ST_SCAN;
            selQ   <= '0;
            cntQ   <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl.loadResult = resultValid;
    ctl.showDigit  = (stateQ == ST_SCAN);
    ctl.digitSel   = selQ;
    strobeFire     = fire;
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_en
    assign digitEn[NUM_DIGITS-1-g] = (stateQ == ST_SCAN) && (selQ == SEL_W'(g));
  end

  // R2: never more than one digit driven
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rstN) $onehot0(digitEn))
    else $error("digit enables not one-hot");
  // R3: slot counter stays inside the current slot length
  p_slot_bound_r3: assert property (@(posedge clk) disable iff (!rstN) cntQ <= slotLast)
    else $error("slot counter overran");
  // R9: a result always restarts at the leading digit with five strobes owed
  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
      resultValid |=> (digitEn[NUM_DIGITS-1] && cntQ == '0 && pendQ == PEND_FULL))
    else $error("result did not restart scan");
  // R8: a blanked display stays dark until released
  p_blank_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      (stateQ == ST_BLANK && !resultValid && !refIntStart) |=> (digitEn == '0))
    else $error("blank display lit");
endmodule

// File: rtl/bcd_scan_data.sv
module bcd_scan_data
  import bcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 5,
  parameter int DIGIT_W    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  scanCtl_t                      ctl,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] resultDigits,
  input  logic                          resultOvr,
  output logic [DIGIT_W-1:0]            bcdOut
);
  localparam int BUS_W = NUM_DIGITS * DIGIT_W;

  logic [BUS_W-1:0]   digitsQ;
  logic               ovrQ;
  logic [DIGIT_W-1:0] pick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      digitsQ <= '0;
      ovrQ    <= 1'b0;
    end else if (ctl.loadResult) begin
      digitsQ <= resultDigits;
      ovrQ    <= resultOvr;
    end
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (ctl.digitSel == SEL_W'(i)) pick = digitsQ[(NUM_DIGITS-1-i)*DIGIT_W +: DIGIT_W];
    end
    bcdOut = (ctl.showDigit && !ovrQ) ? pick : '0;
  end

  // R6: data only moves when the slot selection moves or a result is loaded
  p_bcd_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      ($stable(ctl.digitSel) && $stable(ctl.showDigit) && !$past(ctl.loadResult)) |-> $stable(bcdOut))
    else $error("BCD bus changed inside a slot");
endmodule

// File: rtl/bcd_scanner.sv
module bcd_scanner
  import bcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS  = 5,
  parameter int DIGIT_W     = 4,
  parameter int LEAD_SLOT   = 201,
  parameter int SLOT        = 200,
  parameter int LEAD_STROBE = 101,
  parameter int STROBE_AT   = 100
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          resultValid,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] resultDigits,
  input  logic                          resultOvr,
  input  logic                          refIntStart,
  output logic [NUM_DIGITS-1:0]         digitEn,
  output logic [DIGIT_W-1:0]            bcdOut,
  output logic                          strobeN
);
  scanCtl_t ctl;
  logic     strobeFire;

  bcd_scan_ctrl #(
    .NUM_DIGITS(NUM_DIGITS), .LEAD_SLOT(LEAD_SLOT), .SLOT(SLOT),
    .LEAD_STROBE(LEAD_STROBE), .STROBE_AT(STROBE_AT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .resultOvr(resultOvr),
    .refIntStart(refIntStart), .ctl(ctl), .strobeFire(strobeFire), .digitEn(digitEn)
  );

  bcd_scan_data #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .resultDigits(resultDigits),
    .resultOvr(resultOvr), .bcdOut(bcdOut)
  );

  bcd_scan_strobe u_strobe (.clk(clk), .rstN(rstN), .fire(strobeFire), .strobeN(strobeN));
endmodule

// File: tb/bcd_scanner_test.sv
module bcd_scanner_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN;
  logic        resultValid;
  logic [19:0] resultDigits;
  logic        resultOvr;
  logic        refIntStart;
  logic [4:0]  digitEn;
  logic [3:0]  bcdOut;
  logic        strobeN;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // reference model state
  int          mMode = 0;   // 0 idle, 1 scanning, 2 blanked
  int          mT = 0;      // edges since the current scan started
  bit          mFirst = 0;  // scan was started by a result (strobes owed)
  bit          mOvr = 0;
  logic [19:0] mDig = '0;
  bit          expStrobe = 0;

  always #2.5 clk = ~clk;

  bcd_scanner uut (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .resultDigits(resultDigits),
    .resultOvr(resultOvr), .refIntStart(refIntStart), .digitEn(digitEn),
    .bcdOut(bcdOut), .strobeN(strobeN)
  );

  function automatic int slotIdx(int t);
    int p = t % 1001;
    if (p < 201) return 0;
    return 1 + (p - 201) / 200;
  endfunction

  function automatic logic [4:0] expEn();
    if (mMode != 1) return 5'd0;
    return 5'd1 << (4 - slotIdx(mT));
  endfunction

  function automatic logic [3:0] expBcd();
    int k;
    if (mMode != 1 || mOvr) return 4'd0;
    k = 4 - slotIdx(mT);
    return mDig[k*4 +: 4];
  endfunction

  function automatic bit strobeTime(int t);
    return (t == 101) || (t == 301) || (t == 501) || (t == 701) || (t == 901);
  endfunction

  function automatic logic [19:0] randDigits();
    logic [19:0] d;
    for (int i = 0; i < 5; i++) d[i*4 +: 4] = 4'($urandom % 10);
    return d;
  endfunction

  task automatic modelStep(bit rv, logic [19:0] rd, bit ro, bit ri);
    expStrobe = 0;
    if (rv) begin
      mMode = 1; mT = 0; mFirst = 1; mOvr = ro; mDig = rd;
    end else if (mMode == 1) begin
      mT++;
      if (mFirst && strobeTime(mT)) begin
        expStrobe = 1;
        if (mOvr && mT == 901) mMode = 2;
      end
    end else if (mMode == 2 && ri) begin
      mMode = 1; mT = 0; mFirst = 0;
    end
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s at %0t: actual=%0h expected=%0h", req, what, $time, act, exp);
    end
  endtask

  // Called at 3 ns after a rising edge; applies inputs for the next edge.
  task automatic cycle(bit rv, logic [19:0] rd, bit ro, bit ri, string tag);
    logic [4:0] e;
    resultValid = rv; resultDigits = rd; resultOvr = ro; refIntStart = ri;
    @(posedge clk);
    modelStep(rv, rd, ro, ri);
    #1;
    e = expEn();
    check(digitEn === e, (mMode == 2) ? {tag, " R8"} : {tag, " R2 R3"}, "digitEn", digitEn, e);
    check(bcdOut === expBcd(), mOvr ? {tag, " R7"} : {tag, " R6"}, "bcdOut", bcdOut, expBcd());
    check(strobeN === !expStrobe, {tag, " R4 R5"}, "strobeN first half", strobeN, !expStrobe);
    #2;
    check(strobeN === 1'b1, {tag, " R4"}, "strobeN second half", strobeN, 1);
  endtask

  task automatic idle(int n, string tag);
    repeat (n) cycle(0, 20'd0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  initial begin
    void'($urandom(32'h5eed_0135));
    rstN = 0; resultValid = 0; resultDigits = '0; resultOvr = 0; refIntStart = 0;
    repeat (3) @(posedge clk);
    #1;
    check(digitEn === 5'd0, "R1", "reset digitEn", digitEn, 0);
    check(bcdOut === 4'd0, "R1", "reset bcdOut", bcdOut, 0);
    check(strobeN === 1'b1, "R1", "reset strobeN", strobeN, 1);
    #2;
    rstN = 1;
    cycle(0, 20'd0, 0, 1, "R1");   // release pulse while idle: ignored
    idle(5, "R1");

    // Normal result, run across three scans (strobes only in the first)
    cycle(1, 20'h31415, 0, 0, "R6");
    idle(2300, "R5");

    // Release pulses during a live scan have no effect
    for (int k = 0; k < 4; k++) begin
      idle(50 + int'($urandom % 250), "R10");
      cycle(0, 20'd0, 0, 1, "R10");
    end

    // New result in the middle of a scan
    cycle(1, randDigits(), 0, 0, "R9");
    idle(300 + int'($urandom % 600), "R9");
    cycle(1, randDigits(), 0, 0, "R9");
    idle(1100, "R9");

    // Overrange: zero data, blank after fifth strobe, release resumes without strobes
    cycle(1, 20'h98765, 1, 0, "R7");
    idle(1000 + int'($urandom % 300), "R8");
    cycle(0, 20'd0, 0, 1, "R8");
    idle(2100, "R8");

    // Result and release pulse in the same cycle while blanked
    cycle(1, randDigits(), 1, 0, "R11");
    idle(950, "R11");
    cycle(1, 20'h12345, 0, 1, "R11");
    idle(1010, "R11");

    // Random phase
    for (int it = 0; it < 40; it++) begin
      int sel = int'($urandom % 4);
      if (sel == 0)      cycle(1, randDigits(), bit'($urandom % 2), 0, "R9");
      else if (sel == 1) cycle(0, 20'd0, 0, 1, "R10");
      else if (sel == 2) cycle(1, randDigits(), 1, bit'($urandom % 2), "R11");
      else               cycle(0, 20'd0, 0, 0, "R2");
      idle(int'($urandom % 1400), "R3");
    end

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R1 watchdog: actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule